// File: doc/BRIEF.md
# Video Snapshot Capture Controller

This block watches a 10-bit parallel digital video word stream and keeps a small on-chip buffer sized for a few lines. Timing reference sequences (TRS) in the stream are decoded to keep track of the current field and of a line count within that field. A trigger made of a field value and a line number picks the place in the frame where recording starts. Recording begins at the start-of-active-video code of the matching line and stops when the buffer holds its full depth of words.

Once the buffer is full it is frozen. Later video cannot change it until the block is armed again. A host reads the frozen words at any address through a plain address and data port. For live adjustment work, an optional timed retrigger mode re-arms the block by itself once the buffer has stayed frozen for a programmable number of clock cycles. The next snapshot then follows without host action.

Top module: `vid_snapshot_ctrl`

## Requirements
- R1: After reset the status output reads idle. The status code is 0 for idle, 1 for armed, 2 for capturing and 3 for frozen.
- R2: A TRS is detected when three valid words 0x3FF, 0x000 and 0x000 are followed by a fourth valid word. In that fourth word, bit 8 is the field flag and bit 6 is the line-end flag. A value of 1 marks end of active video (EAV) and 0 marks start of active video (SAV). Cycles with `vid_valid` low do not take part in the sequence.
- R3: The line count goes up by one on each EAV whose field flag equals the stored field. An EAV whose field flag differs from the stored field stores the new field value and sets the line count to 0.
- R4: An `arm` pulse in the idle or frozen state moves the status to armed on the next clock. The status always follows the state rules R4 to R10.
- R5: In the armed state, an SAV seen while the stored field equals `trig_field` and the line count equals `trig_line` moves the status to capturing. The next valid word is stored at buffer address 0.
- R6: While capturing, each valid word is stored at the next address, and cycles with `vid_valid` low store nothing. The word that fills the last address moves the status to frozen.
- R7: While frozen, the buffer contents do not change. `rd_data` returns the word at `rd_addr` one clock after the address is presented.
- R8: An `arm` pulse during capture is ignored, and capture continues.
- R9: An `abort` pulse returns the status to idle from any state on the next clock, and it takes priority over `arm`.
- R10: With `retrig_en` high, a frozen block returns to armed on the clock edge after it has spent `retrig_interval`+1 edges frozen. With `retrig_en` low it stays frozen.
- R11: An SAV on a line whose field or line count does not match the trigger leaves an armed block armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_valid | input | 1 | Qualifies `vid_word` |
| vid_word | input | DW | Incoming video word |
| trig_field | input | 1 | Field value that the trigger needs |
| trig_line | input | LINE_W | Line count within the field that the trigger needs |
| arm | input | 1 | Single-cycle arm request |
| abort | input | 1 | Single-cycle abort request |
| retrig_en | input | 1 | Enables the timed retrigger |
| retrig_interval | input | TIMER_W | Frozen dwell before the automatic re-arm |
| rd_addr | input | ADDR_W | Buffer read address |
| rd_data | output | DW | Buffer word, registered |
| status | output | 2 | Idle, armed, capturing or frozen |

## Verification
The hardest condition to reach is a trigger on the right line. It needs a field transition, an exact count of EAV codes and a matching SAV, all in complete four-word TRS runs that are broken up by invalid cycles. The bench builds whole lines of video, EAV first, then blanking, then SAV and active words, and flips the field flag between lines. Lines with non-matching SAV codes go past before the matching one. A behavioural model that follows the stream word by word predicts the cycle in which capture starts, the cycle in which the buffer freezes, and the exact timed re-arm edge. That edge is measured by counting idle cycles after the freeze.

// File: rtl/snap_pkg.sv
package snap_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ARMED  = 2'd1,
      ST_CAPT   = 2'd2,
      ST_FROZEN = 2'd3
   } snap_state_t;
endpackage

// File: rtl/trs_detect.sv
module trs_detect #(
   parameter int DW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vid_valid,
   input  logic [DW-1:0] vid_word,
   output logic          code_hit,
   output logic          code_fld,
   output logic          code_end
);
   localparam logic [DW-1:0] ONES  = {DW{1'b1}};
   localparam logic [DW-1:0] ZEROS = '0;

   logic [DW-1:0] hist_q [3];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) hist_q[i] <= '0;
      end else if (vid_valid) begin
         hist_q[0] <= vid_word;
         hist_q[1] <= hist_q[0];
         hist_q[2] <= hist_q[1];
      end
   end

   assign code_hit = vid_valid && (hist_q[2] == ONES) &&
                     (hist_q[1] == ZEROS) && (hist_q[0] == ZEROS);
   assign code_fld = vid_word[8];
   assign code_end = vid_word[6];
endmodule

// File: rtl/pos_track.sv
module pos_track #(
   parameter int LINE_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              code_hit,
   input  logic              code_fld,
   input  logic              code_end,
   output logic              field_q,
   output logic [LINE_W-1:0] line_q
);
   logic eav;
   assign eav = code_hit && code_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         field_q <= 1'b0;
         line_q  <= '0;
      end else if (eav) begin
         if (code_fld != field_q) begin
            field_q <= code_fld;
            line_q  <= '0;
         end else begin
            line_q  <= line_q + 1'b1;
         end
      end
   end

   AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (eav && code_fld == field_q) |=> line_q == $past(line_q) + 1'b1); // R3
   AST_FIELD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (eav && code_fld != field_q) |=> (line_q == '0 && field_q == $past(code_fld))); // R3
endmodule

// File: rtl/snap_buffer.sv
module snap_buffer #(
   parameter int DW       = 10,
   parameter int DEPTH    = 64,
   parameter bit READ_REG = 1'b1,
   localparam int ADDR_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DW-1:0]     wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DW-1:0]     rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   generate
      if (READ_REG) begin : g_rd_reg
         logic [DW-1:0] rdata_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rdata_q <= '0;
            else        rdata_q <= mem[raddr];
         end
         assign rdata = rdata_q;
      end else begin : g_rd_comb
         assign rdata = mem[raddr];
      end
   endgenerate
endmodule

// File: rtl/snap_fsm.sv
module snap_fsm
   import snap_pkg::*;
#(
   parameter int DEPTH   = 64,
   parameter int LINE_W  = 11,
   parameter int TIMER_W = 16,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               vid_valid,
   input  logic               code_hit,
   input  logic               code_end,
   input  logic               field_q,
   input  logic [LINE_W-1:0]  line_q,
   input  logic               trig_field,
   input  logic [LINE_W-1:0]  trig_line,
   input  logic               arm,
   input  logic               abort,
   input  logic               retrig_en,
   input  logic [TIMER_W-1:0] retrig_interval,
   output snap_state_t        state_q,
   output logic               we,
   output logic [ADDR_W-1:0]  waddr
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   logic [ADDR_W-1:0]  ptr_q;
   logic [TIMER_W-1:0] timer_q;
   logic               sav_go;

   assign sav_go = code_hit && !code_end &&
                   (field_q == trig_field) && (line_q == trig_line);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ptr_q   <= '0;
         timer_q <= '0;
      end else if (abort) begin
         state_q <= ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE:   if (arm) state_q <= ST_ARMED;
            ST_ARMED:  if (sav_go) begin
                          state_q <= ST_CAPT;
                          ptr_q   <= '0;
                       end
            ST_CAPT:   if (vid_valid) begin
                          if (ptr_q == LAST) begin
                             state_q <= ST_FROZEN;
                             timer_q <= '0;
                          end else begin
                             ptr_q <= ptr_q + 1'b1;
                          end
                       end
            ST_FROZEN: if (arm) state_q <= ST_ARMED;
                       else if (retrig_en && timer_q == retrig_interval) state_q <= ST_ARMED;
                       else timer_q <= timer_q + 1'b1;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   assign we    = (state_q == ST_CAPT) && vid_valid;
   assign waddr = ptr_q;

   AST_ENTRY_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CAPT && $past(state_q) != ST_CAPT) |-> $past(state_q) == ST_ARMED); // R5
   AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CAPT && $past(state_q) != ST_CAPT) |-> ptr_q == '0); // R5
   AST_ARM_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CAPT && arm && !abort && !(vid_valid && ptr_q == LAST)) |=> state_q == ST_CAPT); // R8
   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> state_q == ST_IDLE); // R9
   AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FROZEN && !arm && !abort && !retrig_en) |=> state_q == ST_FROZEN); // R7
endmodule

// File: rtl/vid_snapshot_ctrl.sv
module vid_snapshot_ctrl
   import snap_pkg::*;
#(
   parameter int DW       = 10,
   parameter int DEPTH    = 64,
   parameter int LINE_W   = 11,
   parameter int TIMER_W  = 16,
   parameter bit READ_REG = 1'b1,
   localparam int ADDR_W  = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               vid_valid,
   input  logic [DW-1:0]      vid_word,
   input  logic               trig_field,
   input  logic [LINE_W-1:0]  trig_line,
   input  logic               arm,
   input  logic               abort,
   input  logic               retrig_en,
   input  logic [TIMER_W-1:0] retrig_interval,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [DW-1:0]      rd_data,
   output logic [1:0]         status
);
   generate
      if (DW < 10) begin : g_bad_dw
         $error("vid_snapshot_ctrl: DW must be at least 10");
      end
      if (DEPTH < 2 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
         $error("vid_snapshot_ctrl: DEPTH must be a power of two of at least 2");
      end
      if (LINE_W < 1 || TIMER_W < 1) begin : g_bad_cnt
         $error("vid_snapshot_ctrl: counter widths must be positive");
      end
   endgenerate

   logic              code_hit, code_fld, code_end;
   logic              field_q;
   logic [LINE_W-1:0] line_q;
   snap_state_t       state_q;
   logic              we;
   logic [ADDR_W-1:0] waddr;

   trs_detect #(.DW(DW)) u_det (
      .clk(clk), .rst_n(rst_n), .vid_valid(vid_valid), .vid_word(vid_word),
      .code_hit(code_hit), .code_fld(code_fld), .code_end(code_end));

   pos_track #(.LINE_W(LINE_W)) u_pos (
      .clk(clk), .rst_n(rst_n), .code_hit(code_hit), .code_fld(code_fld),
      .code_end(code_end), .field_q(field_q), .line_q(line_q));

   snap_fsm #(.DEPTH(DEPTH), .LINE_W(LINE_W), .TIMER_W(TIMER_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .vid_valid(vid_valid), .code_hit(code_hit),
      .code_end(code_end), .field_q(field_q), .line_q(line_q),
      .trig_field(trig_field), .trig_line(trig_line), .arm(arm), .abort(abort),
      .retrig_en(retrig_en), .retrig_interval(retrig_interval),
      .state_q(state_q), .we(we), .waddr(waddr));

   snap_buffer #(.DW(DW), .DEPTH(DEPTH), .READ_REG(READ_REG)) u_buf (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(vid_word),
      .raddr(rd_addr), .rdata(rd_data));

   assign status = state_q;

   AST_STATUS_RESET: assert property (@(posedge clk)
      $past(!rst_n) |-> status == 2'd0); // R1
endmodule

// File: tb/tb_vid_snapshot_ctrl.sv
module tb_vid_snapshot_ctrl;
   localparam int DW = 10, DEPTH = 16, LINE_W = 11, TIMER_W = 8, ADDR_W = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic vid_valid = 1'b0, trig_field = 1'b0, arm = 1'b0, abort = 1'b0, retrig_en = 1'b0;
   logic [DW-1:0] vid_word = '0;
   logic [LINE_W-1:0] trig_line = '0;
   logic [TIMER_W-1:0] retrig_interval = '0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic [1:0] status;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   vid_snapshot_ctrl #(.DW(DW), .DEPTH(DEPTH), .LINE_W(LINE_W), .TIMER_W(TIMER_W)) dut (
      .clk(clk), .rst_n(rst_n), .vid_valid(vid_valid), .vid_word(vid_word),
      .trig_field(trig_field), .trig_line(trig_line), .arm(arm), .abort(abort),
      .retrig_en(retrig_en), .retrig_interval(retrig_interval),
      .rd_addr(rd_addr), .rd_data(rd_data), .status(status));

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference, updated on every rising edge
   int m_state, m_ptr, m_timer, m_field, m_line, m_rd;
   int h1, h2, h3;
   bit m_rd_known;
   int mem_m [DEPTH];
   bit known [DEPTH];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_ptr = 0; m_timer = 0; m_field = 0; m_line = 0;
         h1 = 0; h2 = 0; h3 = 0; m_rd = 0; m_rd_known = 1'b1;
      end else begin
         bit is_code, cf, ce;
         int nxt;
         is_code = vid_valid && h3 == 'h3FF && h2 == 0 && h1 == 0;
         cf = vid_word[8];
         ce = vid_word[6];
         m_rd = mem_m[rd_addr];
         m_rd_known = known[rd_addr];
         nxt = m_state;
         if (abort) nxt = 0;
         else case (m_state)
            0: if (arm) nxt = 1;
            1: if (is_code && !ce && m_field == int'(trig_field) && m_line == int'(trig_line)) begin
                  nxt = 2; m_ptr = 0;
               end
            2: if (vid_valid) begin
                  mem_m[m_ptr] = vid_word; known[m_ptr] = 1'b1;
                  if (m_ptr == DEPTH - 1) begin nxt = 3; m_timer = 0; end
                  else m_ptr++;
               end
            default: if (arm) nxt = 1;
               else if (retrig_en && m_timer == int'(retrig_interval)) nxt = 1;
               else m_timer = (m_timer + 1) % 256;
         endcase
         m_state = nxt;
         if (is_code && ce) begin
            if (int'(cf) != m_field) begin m_field = cf; m_line = 0; end
            else m_line = (m_line + 1) % 2048;
         end
         if (vid_valid) begin h3 = h2; h2 = h1; h1 = vid_word; end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R4", status, m_state);
         if (m_rd_known) check("R7", rd_data, m_rd);
      end
   end

   task automatic put(bit v, logic [DW-1:0] w);
      vid_valid = v; vid_word = w;
      @(posedge clk); #2;
      vid_valid = 1'b0; vid_word = '0; arm = 1'b0; abort = 1'b0;
   endtask

   function automatic logic [DW-1:0] xyz(bit f, bit e);
      return {1'b1, f, 1'b0, e, 6'b0};
   endfunction

   task automatic trs(bit f, bit e);
      put(1, 10'h3FF); put(1, 10'h000); put(1, 10'h000); put(1, xyz(f, e));
   endtask

   task automatic send_line(bit f, int base, int nact, int arm_at, int abort_at);
      trs(f, 1'b1);
      put(1, 10'h200); put(1, 10'h200);
      trs(f, 1'b0);
      for (int i = 0; i < nact; i++) begin
         if (i % 7 == 3) put(0, '0);
         if (i == arm_at) arm = 1'b1;
         if (i == abort_at) abort = 1'b1;
         put(1, DW'(base + i));
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      check("R1", status, 0);

      send_line(0, 'h100, 6, -1, -1);
      check("R4", status, 0);
      trig_field = 1'b1; trig_line = 11'd1;
      arm = 1'b1; put(0, '0);
      check("R4", status, 1);
      send_line(0, 'h100, 6, -1, -1);
      send_line(0, 'h100, 6, -1, -1);
      check("R11", status, 1);
      send_line(1, 'h120, 6, -1, -1);   // field flips, line 0: no match
      check("R3", status, 1);

      trs(1'b1, 1'b1);                  // EAV -> line 1
      check("R2", status, 1);
      put(1, 10'h200);
      trs(1'b1, 1'b0);                  // matching SAV
      check("R2", status, 2);
      check("R5", status, 2);
      for (int i = 0; i < 20; i++) begin
         if (i == 4) begin put(0, '0); check("R6", status, 2); end
         if (i == 6) arm = 1'b1;
         put(1, DW'('h140 + i));
         if (i == 6) check("R8", status, 2);
         if (i == 14) check("R6", status, 2);
         if (i == 15) check("R6", status, 3);
      end
      send_line(1, 'h300, 10, -1, -1);
      send_line(0, 'h300, 10, -1, -1);
      check("R7", status, 3);
      for (int a = 0; a < DEPTH; a++) begin
         rd_addr = ADDR_W'(a);
         put(0, '0);
         if (a == 0) check("R5", rd_data, 'h140);
         check("R7", rd_data, 'h140 + a);
      end

      arm = 1'b1; put(0, '0);
      check("R4", status, 1);
      abort = 1'b1; put(0, '0);
      check("R9", status, 0);
      arm = 1'b1; abort = 1'b1; put(0, '0);
      check("R9", status, 0);

      // abort during capture: field 0 line 0 matches after the flip
      trig_field = 1'b0; trig_line = 11'd0;
      send_line(1, 'h100, 4, -1, -1);
      arm = 1'b1; put(0, '0);
      send_line(0, 'h180, 12, -1, 5);
      check("R9", status, 0);

      // timed retrigger
      trig_line = 11'd1; retrig_en = 1'b1; retrig_interval = 8'd5;
      arm = 1'b1; put(0, '0);
      send_line(0, 'h1C0, 16, -1, -1);
      check("R6", status, 3);
      begin
         int cnt = 0;
         while (status == 2'd3 && cnt < 50) begin put(0, '0); cnt++; end
         check("R10", cnt, 6);
         check("R10", status, 1);
      end

      retrig_en = 1'b0; trig_line = 11'd2;
      send_line(0, 'h220, 16, -1, -1);
      check("R6", status, 3);
      repeat (20) put(0, '0);
      check("R10", status, 3);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         done = 1'b1;
         checks++; failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule